// File: doc/BRIEF.md
# Trace Output Address Register Unit

This block holds the two registers that tell a trace-byte output engine where to put its next byte: a physical base register and a combined mask/pointer register. The mask/pointer register also carries a 32-bit running output offset in its upper half. From these values the block forms the next write address. In single-region mode the offset wraps inside a power-of-two region. In table mode the address is a pointer to the current table entry.

Software reaches the registers through a simple access port. A request is taken on any cycle where `acc_valid` is high. The response comes one cycle later on `rsp_valid`, with `rsp_fault` and `rsp_rdata`. This port never stalls.

Written trace bytes arrive on a valid/ready stream. A byte counts only in a cycle where `byte_valid` and `byte_ready` are both high. The engine must hold `byte_valid` until it sees ready. Ready falls while tracing is off, in the first cycle of tracing, and while the operational error is set.

When `trace_en` rises, the configuration is checked. A bad configuration raises a sticky operational error instead of causing a write fault.

Top module: `trace_out_addr_unit`

## Requirements
- R1: A write request to either register while `trace_en` is 1 gets `rsp_fault`=1 and changes nothing.
- R2: Bits 6:0 of the mask/pointer register always read as 1. The value after reset is 7Fh, and writes to those bits have no effect.
- R3: A base write gets `rsp_fault`=1 and is discarded if it sets any bit in 6:0 or any bit at or above PA_W (default 40).
- R4: In single-region mode (`table_mode`=0), `wr_addr` equals base OR (offset AND mask). The mask is the 32-bit value in bits 31:0 of the mask/pointer register.
- R5: When `trace_en` rises in single-region mode and the mask is not of the form 2^k−1, `op_err` becomes 1 on the following cycle.
- R6: When `trace_en` rises in single-region mode and base bits 31:0 share a 1 with the mask, `op_err` becomes 1 on the following cycle.
- R7: In table mode a base with nonzero bits 11:7 is written without a fault. `op_err` then becomes 1 the cycle after `trace_en` rises.
- R8: In table mode, `wr_addr` equals base plus (mask/pointer bits 31:7 shifted left by 3). The low seven bits are ignored.
- R9: Each accepted byte adds 1 to the offset in bits 63:32 of the mask/pointer register, wrapping modulo 2^32. That field can also be written.
- R10: `op_err` stays set until a write is accepted to either register while `trace_en` is 0. While it is set, `byte_ready` is 0 and the offset does not move.
- R11: A read never faults. It returns the register value of the request cycle one cycle later, with `rsp_valid`=1.
- R12: `byte_ready` is 1 only when `trace_en` is 1 now, was 1 in the previous cycle, and `op_err` is 0.
- R13: After reset, the base reads 0, the mask/pointer register reads 7Fh, and `op_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Register access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 1 | 0 = base register, 1 = mask/pointer register |
| acc_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_fault | output | 1 | Request was refused |
| rsp_rdata | output | 64 | Read data (0 for writes) |
| trace_en | input | 1 | Tracing enabled |
| table_mode | input | 1 | 1 = table mode, 0 = single region |
| byte_valid | input | 1 | Engine has written one trace byte |
| byte_ready | output | 1 | Byte stream ready |
| wr_addr | output | PA_W | Next write address or table entry pointer |
| op_err | output | 1 | Sticky operational error |

## Verification
`wr_addr` and `byte_ready` are combinational from the registered state and the present inputs, so they are due in the same cycle. Access responses, offset steps and the error flag appear one clock edge after the request, byte or enable edge. The bench advances a behavioural model at every rising edge and compares all outputs 2 ns later, before the next inputs are driven at the falling edge. Each result is therefore compared in exactly the cycle it is due.

// File: rtl/trace_out_pkg.sv
package trace_out_pkg;
  typedef enum logic {SEL_BASE = 1'b0, SEL_MASK = 1'b1} tou_sel_e;

  localparam int unsigned LOW_ONES  = 7;
  localparam int unsigned TBL_ALIGN = 12;
  localparam int unsigned ACC_W     = 64;

  function automatic logic is_low_run(input logic [31:0] m);
    logic [31:0] nxt;
    nxt = m + 32'd1;
    return (nxt & m) == 32'd0;
  endfunction
endpackage

// File: rtl/tou_regs.sv
module tou_regs
  import trace_out_pkg::*;
#(
  parameter int unsigned PA_W   = 40,
  parameter int unsigned MASK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_sel,
  input  logic [ACC_W-1:0]  acc_wdata,
  input  logic              trace_en,
  input  logic              byte_take,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [ACC_W-1:0]  rsp_rdata,
  output logic [PA_W-1:0]   base_o,
  output logic [MASK_W-1:0] mask_o,
  output logic [MASK_W-1:0] off_o,
  output logic              wr_ok
);
  localparam int unsigned HI_W = ACC_W - PA_W;

  logic [PA_W-1:LOW_ONES]   base_q;
  logic [MASK_W-1:LOW_ONES] mhi_q;
  logic [MASK_W-1:0]        off_q;
  logic                     base_bad, fault_now;
  logic [ACC_W-1:0]         rd_val;

  assign base_o = {base_q, {LOW_ONES{1'b0}}};
  assign mask_o = {mhi_q, {LOW_ONES{1'b1}}};
  assign off_o  = off_q;

  generate
    if (HI_W > 0) begin : g_hi
      assign base_bad = (|acc_wdata[LOW_ONES-1:0]) | (|acc_wdata[ACC_W-1:PA_W]);
    end else begin : g_nohi
      assign base_bad = |acc_wdata[LOW_ONES-1:0];
    end
  endgenerate

  always_comb begin
    fault_now = 1'b0;
    if (acc_valid && acc_write)
      fault_now = trace_en || ((tou_sel_e'(acc_sel) == SEL_BASE) && base_bad);
  end

  assign wr_ok  = acc_valid && acc_write && !fault_now;
  assign rd_val = (tou_sel_e'(acc_sel) == SEL_MASK) ? {off_q, mask_o}
                                                    : ACC_W'(base_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q    <= '0;
      mhi_q     <= '0;
      off_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc_valid;
      rsp_fault <= fault_now;
      rsp_rdata <= (acc_valid && !acc_write) ? rd_val : '0;
      if (wr_ok && tou_sel_e'(acc_sel) == SEL_BASE)
        base_q <= acc_wdata[PA_W-1:LOW_ONES];
      if (wr_ok && tou_sel_e'(acc_sel) == SEL_MASK) begin
        mhi_q <= acc_wdata[MASK_W-1:LOW_ONES];
        off_q <= acc_wdata[MASK_W+31:MASK_W];
      end else if (byte_take) begin
        off_q <= off_q + MASK_W'(1);
      end
    end
  end

  p_lock_fault_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_write && trace_en |=> rsp_fault);
  p_base_locked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    trace_en |=> $stable(base_q));
  p_read_ok_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_write |=> rsp_valid && !rsp_fault);
  p_off_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_take |=> off_q == $past(off_q) + MASK_W'(1));
endmodule

// File: rtl/tou_cfg_check.sv
module tou_cfg_check
  import trace_out_pkg::*;
#(
  parameter int unsigned PA_W   = 40,
  parameter int unsigned MASK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trace_en,
  input  logic              table_mode,
  input  logic [PA_W-1:0]   base_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              clr,
  output logic              ten_q,
  output logic              op_err
);
  logic rise, bad_single, bad_table, bad;

  assign rise       = trace_en && !ten_q;
  assign bad_single = !is_low_run(mask_i) || (|(base_i[MASK_W-1:0] & mask_i));
  assign bad_table  = |base_i[TBL_ALIGN-1:LOW_ONES];
  assign bad        = table_mode ? bad_table : bad_single;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ten_q  <= 1'b0;
      op_err <= 1'b0;
    end else begin
      ten_q <= trace_en;
      if (clr)
        op_err <= 1'b0;
      else if (rise && bad)
        op_err <= 1'b1;
    end
  end

  p_err_only_at_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_err) |-> $past(rise));
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    op_err && !clr |=> op_err);
endmodule

// File: rtl/tou_addr_gen.sv
module tou_addr_gen
  import trace_out_pkg::*;
#(
  parameter int unsigned PA_W   = 40,
  parameter int unsigned MASK_W = 32
) (
  input  logic              table_mode,
  input  logic [PA_W-1:0]   base_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [MASK_W-1:0] off_i,
  output logic [PA_W-1:0]   wr_addr
);
  localparam int unsigned TOFF_W = MASK_W - LOW_ONES + 3;

  logic [TOFF_W-1:0] tbl_off;
  logic [PA_W-1:0]   single_addr, entry_ptr;

  assign tbl_off     = {mask_i[MASK_W-1:LOW_ONES], 3'b000};
  assign single_addr = base_i | PA_W'(off_i & mask_i);
  assign entry_ptr   = base_i + PA_W'(tbl_off);
  assign wr_addr     = table_mode ? entry_ptr : single_addr;
endmodule

// File: rtl/trace_out_addr_unit.sv
module trace_out_addr_unit
  import trace_out_pkg::*;
#(
  parameter int unsigned PA_W   = 40,
  parameter int unsigned MASK_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic             acc_sel,
  input  logic [63:0]      acc_wdata,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [63:0]      rsp_rdata,
  input  logic             trace_en,
  input  logic             table_mode,
  input  logic             byte_valid,
  output logic             byte_ready,
  output logic [PA_W-1:0]  wr_addr,
  output logic             op_err
);
  logic [PA_W-1:0]   base_w;
  logic [MASK_W-1:0] mask_w, off_w;
  logic              wr_ok, ten_q, byte_take;

  assign byte_ready = trace_en && ten_q && !op_err;
  assign byte_take  = byte_valid && byte_ready;

  tou_regs #(.PA_W(PA_W), .MASK_W(MASK_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_sel(acc_sel), .acc_wdata(acc_wdata), .trace_en(trace_en),
    .byte_take(byte_take), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_rdata(rsp_rdata), .base_o(base_w), .mask_o(mask_w), .off_o(off_w),
    .wr_ok(wr_ok));

  tou_cfg_check #(.PA_W(PA_W), .MASK_W(MASK_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .table_mode(table_mode),
    .base_i(base_w), .mask_i(mask_w), .clr(wr_ok), .ten_q(ten_q),
    .op_err(op_err));

  tou_addr_gen #(.PA_W(PA_W), .MASK_W(MASK_W)) u_addr (
    .table_mode(table_mode), .base_i(base_w), .mask_i(mask_w), .off_i(off_w),
    .wr_addr(wr_addr));

  p_no_take_in_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    op_err |=> $stable(off_w) || $past(wr_ok));
endmodule

// File: tb/trace_out_addr_unit_bench.sv
module trace_out_addr_unit_bench;
  localparam int PA = 40;
  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_write = 0, acc_sel = 0;
  logic [63:0] acc_wdata = 0;
  logic trace_en = 0, table_mode = 0, byte_valid = 0;
  logic rsp_valid, rsp_fault, byte_ready, op_err;
  logic [63:0] rsp_rdata;
  logic [PA-1:0] wr_addr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  trace_out_addr_unit u_trace_out_addr_unit (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_sel(acc_sel), .acc_wdata(acc_wdata), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata), .trace_en(trace_en),
    .table_mode(table_mode), .byte_valid(byte_valid), .byte_ready(byte_ready),
    .wr_addr(wr_addr), .op_err(op_err));

  // behavioural reference state
  logic [63:0] m_base;
  logic [31:0] m_mask, m_off;
  bit m_err, m_tq, m_rv, m_rf;
  logic [63:0] m_rd;

  always @(posedge clk) begin
    bit rise, take, bad;
    if (!rst_n) begin
      m_base = 0; m_mask = 32'h7f; m_off = 0; m_err = 0; m_tq = 0;
      m_rv = 0; m_rf = 0; m_rd = 0;
    end else begin
      rise = trace_en && !m_tq;
      take = byte_valid && trace_en && m_tq && !m_err;
      m_rv = acc_valid; m_rf = 0; m_rd = 0;
      if (acc_valid) begin
        if (!acc_write) m_rd = acc_sel ? {m_off, m_mask} : m_base;
        else if (trace_en) m_rf = 1;
        else if (!acc_sel) begin
          if (acc_wdata[6:0] != 0 || (acc_wdata >> PA) != 0) m_rf = 1;
          else begin m_base = acc_wdata; m_err = 0; end
        end else begin
          m_mask = acc_wdata[31:0] | 32'h7f; m_off = acc_wdata[63:32]; m_err = 0;
        end
      end
      if (take) m_off = m_off + 1;
      if (rise) begin
        if (table_mode) bad = m_base[11:7] != 0;
        else bad = (((m_mask + 32'd1) & m_mask) != 0) || ((m_base[31:0] & m_mask) != 0);
        if (bad) m_err = 1;
      end
      m_tq = trace_en;
    end
  end

  task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    logic [63:0] ea;
    #2;
    if (rst_n && !done) begin
      ea = table_mode ? m_base + 64'(((m_mask >> 7) << 3)) : m_base | 64'(m_off & m_mask);
      cmp("R4 R8 R9 wr_addr", 64'(wr_addr), 64'(ea[PA-1:0]));
      cmp("R5 R6 R7 R10 op_err", 64'(op_err), 64'(m_err));
      cmp("R12 R10 byte_ready", 64'(byte_ready), 64'(trace_en && m_tq && !m_err));
      cmp("R11 rsp_valid", 64'(rsp_valid), 64'(m_rv));
      if (m_rv) begin
        cmp("R1 R3 R7 R11 rsp_fault", 64'(rsp_fault), 64'(m_rf));
        cmp("R2 R9 R11 R13 rsp_rdata", rsp_rdata, m_rd);
      end
    end
  end

  task automatic cyc(); @(negedge clk); acc_valid = 0; endtask
  task automatic acc(input bit w, input bit s, input logic [63:0] d);
    @(negedge clk); acc_valid = 1; acc_write = w; acc_sel = s; acc_wdata = d;
    @(negedge clk); acc_valid = 0;
  endtask
  task automatic run_bytes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); byte_valid = ($urandom % 4) != 0;
    end
    @(negedge clk); byte_valid = 0;
  endtask
  task automatic enable(input bit tm);
    @(negedge clk); table_mode = tm; trace_en = 1;
  endtask
  task automatic disable_tr();
    @(negedge clk); trace_en = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R13 reset values, R2 low bits
    acc(0, 0, 0); acc(0, 1, 0);
    acc(1, 1, 64'h0000_0010_0000_0000); // R2: low bits written 0, read 7F
    acc(0, 1, 0);
    // single region 4 KB, R4/R9
    acc(1, 0, 64'h0000_0001_0000_0000);
    acc(1, 1, 64'h0000_0FF0_0000_0FFF);
    enable(0);
    run_bytes(300);
    acc(0, 1, 0);                         // R11 read while tracing
    acc(1, 0, 64'h0000_0002_0000_0000);   // R1 locked
    acc(1, 1, 64'h0);                     // R1 locked
    acc(0, 0, 0);
    disable_tr();
    // R3 reserved bits
    acc(1, 0, 64'h0000_0002_0000_0040);
    acc(1, 0, 64'h0100_0000_0000_0000);
    acc(0, 0, 0);
    // R5 non-contiguous mask, R10 blocked and cleared
    acc(1, 1, 64'h0000_0000_0001_0FFF);
    enable(0); run_bytes(20); acc(0, 1, 0);
    disable_tr(); cyc(); acc(0, 1, 0);
    acc(1, 1, 64'h0000_0000_0000_0FFF);  // clears
    // R6 overlap
    acc(1, 0, 64'h0000_0000_0000_0800);
    enable(0); run_bytes(10); disable_tr();
    acc(1, 0, 64'h0000_0001_0000_0000);
    // full 4 GB mask with wrap, R9
    acc(1, 1, 64'hFFFF_FFFE_FFFF_FFFF);
    acc(1, 0, 64'h0000_0100_0000_0000);
    enable(0); run_bytes(12); disable_tr(); acc(0, 1, 0);
    // table mode R8 and R7
    acc(1, 0, 64'h0000_0000_2000_0000);
    acc(1, 1, 64'h0000_0000_0123_45FF);
    enable(1); run_bytes(8); disable_tr();
    acc(1, 0, 64'h0000_0000_2000_0100);  // R7 no fault
    enable(1); run_bytes(8); disable_tr();
    acc(1, 1, 64'h0000_0000_0000_0000);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      acc_valid = ($urandom % 5) == 0;
      acc_write = $urandom % 2;
      acc_sel   = $urandom % 2;
      acc_wdata = {$urandom, $urandom};
      if ($urandom % 3 == 0) acc_wdata = acc_wdata & 64'h0000_00FF_FFFF_FF80;
      if ($urandom % 2 == 0) acc_wdata[31:0] = (32'h1 << ($urandom % 25 + 7)) - 1;
      byte_valid = $urandom % 2;
      if ($urandom % 40 == 0) trace_en = !trace_en;
      if ($urandom % 60 == 0) table_mode = !table_mode;
    end
    @(negedge clk); acc_valid = 0; byte_valid = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule